// File: doc/BRIEF.md
# Synchronous Burst ROM Read Interface

This block is the clocked command front end of a synchronous read-only memory. All inputs are sampled on the rising clock edge. The strobe inputs carry three operations: a mode-register cycle, a row open and a column read. A mode-register cycle loads the read timing and the beat order from the multiplexed address pins. A row open latches a row address. A column read then starts an eight-beat burst. The burst appears on a registered data output after a programmable number of cycles.

A strap input selects the organisation. In double-word organisation the output is 32 bits wide and the column is 8 bits. In word organisation the output is 16 bits wide, carried on the low half of the output bus, and the column is 9 bits. The storage is a small array whose contents are computed from the address, so no memory is instantiated.

A clock-enable input freezes the whole block one cycle after it is sampled low. An output mask blanks single beats without disturbing the burst. A column read that comes too soon after the row open is refused, and a sticky error flag records it.

Top module: `srom_burst_read`

## Requirements
- R1: After reset, dout_valid, dout and ras_cas_err are 0. The mode defaults are column latency 2, row latency 1 and sequential order.
- R2: Commands are decoded only when cs_n is 0, from {mrs_n, ras_n, cas_n}: 3'b011 is a mode-register cycle, 3'b101 is a row open (row = addr[12:0]) and 3'b110 is a column read. All other codes do nothing.
- R3: A mode-register cycle loads three fields. addr[3] selects the order (0 sequential, 1 interleaved). addr[6:4] is the column-latency code: codes 2 to 7 mean that many cycles, code 0 means 8, and code 1 is reserved and gives 2. addr[7] selects row latency 2 when 1 and row latency 1 when 0. addr[2:0] has no effect.
- R4: A read accepted at active edge n loads beat i (i = 0..7) into the output registers at active edge n+CL+i. The output is invalid at every other edge up to and including n+CL+8.
- R5: Within a burst, the upper column bits stay at the start column. The low 3 bits are (s+i) mod 8 in sequential order and s XOR i in interleaved order, where s is the start value of those bits.
- R6: With f = row[7:0] XOR {3'b000,row[12:8]}, the double word at column d is {f, d, ~d, f^d}. In 32-bit organisation the column is addr[7:0] and each beat outputs the double word of its column.
- R7: With word_mode = 1, the column is addr[8:0]. A beat at column c outputs, on dout[15:0], the upper half of the double word at c[8:1] when c[0] = 1 and the lower half when c[0] = 0. dout[31:16] is 0.
- R8: dqm = 1 (with cs_n = 0) at the edge that loads a beat blanks that beat: dout_valid is 0 and dout is 0. The following beats keep their order and timing.
- R9: An edge is active only if cke was 1 at the previous rising edge. At an inactive edge no state or output changes, and the burst timing is delayed by that edge.
- R10: A column read is refused and ras_cas_err is set if no row has been opened since reset, or if fewer active edges than the row latency have passed since the row open. A refused read produces no burst. ras_cas_err stays set until the next mode-register cycle, which clears it.
- R11: When no beat is due, dout_valid is 0 and dout is 0.
- R12: While cs_n is 1, the strobes, addr and dqm are ignored. A running burst continues and the open row is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes the block from the next edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| mrs_n | input | 1 | Mode-register strobe, active low |
| addr | input | 13 | Multiplexed row, column and mode key |
| dqm | input | 1 | Output mask for the beat loaded at this edge |
| word_mode | input | 1 | Strap: 1 = 16-bit words, 0 = 32-bit double words |
| dout | output | 32 | Burst data, zero when not valid |
| dout_valid | output | 1 | Data-driven flag (low models high impedance) |
| ras_cas_err | output | 1 | Sticky flag for a column read that was refused |

## Verification
The assertions assume that reset is held low from time zero. They also assume that the word_mode strap changes only while no burst is running and the output is invalid, because the upper-half-zero property has no memory of which organisation loaded the current beat. The stimulus holds the strap steady across every burst. It issues mode-register cycles only while idle and keeps cke high through reset. Frozen-clock windows are placed inside a burst, so that the stability property sees both a held output beat and a resumed one.

// File: rtl/srom_pkg.sv
// Package: shared command and mode types for the synchronous burst ROM.
// Assumes the mode key is 8 bits, with the field positions given below.
package srom_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_MODE = 2'd1,
        CMD_ACT  = 2'd2,
        CMD_READ = 2'd3
    } srom_cmd_e;

    localparam int CL_W         = 4;
    localparam int KEY_TYPE_BIT = 3;
    localparam int KEY_CL_LSB   = 4;
    localparam int KEY_RL_BIT   = 7;

    typedef struct packed {
        logic            ilv;
        logic            rl2;
        logic [CL_W-1:0] cl;
    } srom_mode_t;

    localparam srom_mode_t MODE_RESET = '{ilv: 1'b0, rl2: 1'b0, cl: 4'd2};

endpackage

// File: rtl/srom_mode_reg.sv
// Mode register: decodes the address key into the order, row latency and
// column latency fields. Assumes the load strobe already includes clock enable.
module srom_mode_reg
    import srom_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:3] key,
    output srom_mode_t mode_o
);

    srom_mode_t next_mode;
    logic [2:0] code;

    // Turns the key bits into mode fields, mapping the special latency codes.
    always_comb begin
        code          = key[KEY_CL_LSB+2:KEY_CL_LSB];
        next_mode.ilv = key[KEY_TYPE_BIT];
        next_mode.rl2 = key[KEY_RL_BIT];
        case (code)
            3'd0:    next_mode.cl = 4'd8;
            3'd1:    next_mode.cl = 4'd2;
            default: next_mode.cl = {1'b0, code};
        endcase
    end

    // Holds the programmed mode until the next mode-register cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_o <= MODE_RESET;
        else if (load)
            mode_o <= next_mode;
    end

endmodule

// File: rtl/srom_row_ctrl.sv
// Row control: latches the open row, counts the active edges since the row
// open, refuses early or row-less column reads and keeps the sticky error.
// Assumes ROW_W >= COL_W and that en is the registered clock enable.
module srom_row_ctrl
    import srom_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  srom_cmd_e        cmd,
    input  logic [ROW_W-1:0] addr,
    input  logic             rl2,
    input  logic             word_mode,
    output logic             read_go,
    output logic [COL_W-1:0] read_col,
    output logic [ROW_W-1:0] row_q,
    output logic             err
);

    logic       row_open;
    logic [1:0] age;
    logic [1:0] need;
    logic       ok;

    assign need     = rl2 ? 2'd2 : 2'd1;
    assign ok       = row_open && (age >= need);
    assign read_go  = en && (cmd == CMD_READ) && ok;
    assign read_col = word_mode ? addr[COL_W-1:0] : {1'b0, addr[COL_W-2:0]};

    // Tracks the row state, the saturating age and the refused-read flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_open <= 1'b0;
            age      <= 2'd0;
            row_q    <= '0;
            err      <= 1'b0;
        end else if (en) begin
            if (cmd == CMD_ACT) begin
                row_q    <= addr;
                row_open <= 1'b1;
                age      <= 2'd1;
            end else if (row_open && age != 2'd2) begin
                age <= age + 2'd1;
            end
            if (cmd == CMD_READ && !ok)
                err <= 1'b1;
            else if (cmd == CMD_MODE)
                err <= 1'b0;
        end
    end

endmodule

// File: rtl/srom_burst_seq.sv
// Burst sequencer: counts the column latency down, then steps through
// BURST_LEN beat columns in sequential or interleaved order.
// Assumes BURST_LEN is a power of two and cl is at least 1.
module srom_burst_seq
    import srom_pkg::*;
#(
    parameter int COL_W     = 9,
    parameter int BURST_LEN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [CL_W-1:0]  cl,
    input  logic             ilv,
    output logic             fire,
    output logic [COL_W-1:0] beat_col,
    output logic             active
);

    localparam int BEAT_W = $clog2(BURST_LEN);
    localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BURST_LEN - 1);

    logic [CL_W-1:0]   wait_cnt;
    logic [BEAT_W-1:0] beat;
    logic [COL_W-1:0]  base;
    logic              ilv_q;
    logic [BEAT_W-1:0] low;

    assign fire = active && (wait_cnt == '0);

    // Forms the low column bits of the current beat in the latched order.
    always_comb begin
        if (ilv_q)
            low = base[BEAT_W-1:0] ^ beat;
        else
            low = base[BEAT_W-1:0] + beat;
        beat_col = {base[COL_W-1:BEAT_W], low};
    end

    // Starts, counts down and advances the burst on active edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            wait_cnt <= '0;
            beat     <= '0;
            base     <= '0;
            ilv_q    <= 1'b0;
        end else if (en) begin
            if (start) begin
                active   <= 1'b1;
                wait_cnt <= cl - CL_W'(1);
                beat     <= '0;
                base     <= start_col;
                ilv_q    <= ilv;
            end else if (active) begin
                if (wait_cnt != '0) begin
                    wait_cnt <= wait_cnt - CL_W'(1);
                end else begin
                    beat <= beat + BEAT_W'(1);
                    if (beat == LAST)
                        active <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/srom_array.sv
// Computed ROM contents: derives each double word from the row and column,
// then selects one half in word organisation. Assumes DATA_W/2 > COL_W-1.
module srom_array #(
    parameter int ROW_W  = 13,
    parameter int COL_W  = 9,
    parameter int DATA_W = 32
) (
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    input  logic              word_mode,
    output logic [DATA_W-1:0] data
);

    localparam int HALF_W = DATA_W / 2;
    localparam int DC_W   = COL_W - 1;
    localparam int RB     = HALF_W - DC_W;

    logic [DC_W-1:0]   dcol;
    logic [RB-1:0]     fold;
    logic [HALF_W-1:0] hi;
    logic [HALF_W-1:0] lo;

    // Folds the row, builds both halves and picks the output format.
    always_comb begin
        dcol = word_mode ? col[COL_W-1:1] : col[DC_W-1:0];
        fold = row[RB-1:0] ^ RB'(row[ROW_W-1:RB]);
        hi   = {fold, dcol};
        lo   = {~dcol, fold ^ RB'(dcol)};
        if (word_mode)
            data = {{HALF_W{1'b0}}, (col[0] ? hi : lo)};
        else
            data = {hi, lo};
    end

endmodule

// File: rtl/srom_burst_read.sv
// Top: registers the clock enable, decodes the strobes, and ties the mode
// register, row control, burst sequencer and array to the output registers.
// Assumes word_mode changes only while the output is idle.
module srom_burst_read
    import srom_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int COL_W     = 9,
    parameter int DATA_W    = 32,
    parameter int BURST_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              mrs_n,
    input  logic [ROW_W-1:0]  addr,
    input  logic              dqm,
    input  logic              word_mode,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid,
    output logic              ras_cas_err
);

    logic              cke_q;
    srom_cmd_e         cmd;
    logic              mode_load;
    srom_mode_t        mode;
    logic              read_go;
    logic [COL_W-1:0]  read_col;
    logic [ROW_W-1:0]  row_q;
    logic              fire;
    logic [COL_W-1:0]  beat_col;
    logic              burst_act;
    logic [DATA_W-1:0] data;
    logic              blank;

    // Delays the clock enable so that a low value freezes the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cke_q <= 1'b1;
        else
            cke_q <= cke;
    end

    // Decodes the strobe pattern while the chip is selected.
    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            case ({mrs_n, ras_n, cas_n})
                3'b011:  cmd = CMD_MODE;
                3'b101:  cmd = CMD_ACT;
                3'b110:  cmd = CMD_READ;
                default: cmd = CMD_NOP;
            endcase
        end
    end

    assign mode_load = cke_q && (cmd == CMD_MODE);
    assign blank     = dqm && !cs_n;

    srom_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (mode_load),
        .key    (addr[7:3]),
        .mode_o (mode)
    );

    srom_row_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W)) u_row (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cke_q),
        .cmd       (cmd),
        .addr      (addr),
        .rl2       (mode.rl2),
        .word_mode (word_mode),
        .read_go   (read_go),
        .read_col  (read_col),
        .row_q     (row_q),
        .err       (ras_cas_err)
    );

    srom_burst_seq #(.COL_W(COL_W), .BURST_LEN(BURST_LEN)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cke_q),
        .start     (read_go),
        .start_col (read_col),
        .cl        (mode.cl),
        .ilv       (mode.ilv),
        .fire      (fire),
        .beat_col  (beat_col),
        .active    (burst_act)
    );

    srom_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_array (
        .row       (row_q),
        .col       (beat_col),
        .word_mode (word_mode),
        .data      (data)
    );

    // Loads a due, unmasked beat, and otherwise drives the idle output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout       <= '0;
            dout_valid <= 1'b0;
        end else if (cke_q) begin
            if (fire && !blank) begin
                dout       <= data;
                dout_valid <= 1'b1;
            end else begin
                dout       <= '0;
                dout_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/srom_burst_read_chk.sv
// Checker: temporal properties of the burst ROM outputs, bound into the top.
// Assumes reset is asserted from time zero and word_mode changes only while idle.
module srom_burst_read_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke_q,
    input logic              burst_act,
    input logic              mode_load,
    input logic              word_mode,
    input logic [DATA_W-1:0] dout,
    input logic              dout_valid,
    input logic              ras_cas_err
);

    a_r9_frozen_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_q |=> ($stable(dout) && $stable(dout_valid) && $stable(ras_cas_err)));

    a_r11_idle_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_q && !burst_act) |=> !dout_valid);

    a_r11_invalid_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_valid |-> (dout == '0));

    a_r7_word_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (word_mode && dout_valid) |-> (dout[DATA_W-1:DATA_W/2] == '0));

    a_r10_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_cas_err && !mode_load) |=> ras_cas_err);

endmodule

bind srom_burst_read srom_burst_read_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cke_q       (cke_q),
    .burst_act   (burst_act),
    .mode_load   (mode_load),
    .word_mode   (word_mode),
    .dout        (dout),
    .dout_valid  (dout_valid),
    .ras_cas_err (ras_cas_err)
);

// File: tb/srom_burst_read_test.sv
// Scoreboard bench: driver tasks push the expected output of every edge,
// and a monitor compares them at the following falling edge.
module srom_burst_read_test;

    logic        clk = 1'b0;
    logic        rst_n, cke, cs_n, ras_n, cas_n, mrs_n, dqm, word_mode;
    logic [12:0] addr;
    logic [31:0] dout;
    logic        dout_valid, ras_cas_err;

    always #10 clk = ~clk;

    srom_burst_read uut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .mrs_n(mrs_n), .addr(addr), .dqm(dqm),
        .word_mode(word_mode), .dout(dout), .dout_valid(dout_valid),
        .ras_cas_err(ras_cas_err)
    );

    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    int          q_cyc[$];
    logic [32:0] q_exp[$];
    string       q_tag[$];

    int          cl_m = 2;
    bit          ilv_m = 0;
    logic [12:0] row_m = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] ref_word(logic [12:0] r, logic [8:0] c, bit w);
        logic [7:0]  f, d;
        logic [15:0] hi, lo;
        f  = r[7:0] ^ {3'b000, r[12:8]};
        d  = w ? c[8:1] : c[7:0];
        hi = {f, d};
        lo = {~d, f ^ d};
        if (w) return {16'h0, (c[0] ? hi : lo)};
        return {hi, lo};
    endfunction

    task automatic check(string tag, logic [32:0] act, logic [32:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push(int c, logic [32:0] e, string tag);
        q_cyc.push_back(c);
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    // Monitor: compares every queued expectation once its edge has passed.
    always @(negedge clk) begin
        while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            check(q_tag[0], {dout_valid, dout}, q_exp[0]);
            void'(q_cyc.pop_front());
            void'(q_exp.pop_front());
            void'(q_tag.pop_front());
        end
    end

    task automatic nop_in();
        cs_n = 0; ras_n = 1; cas_n = 1; mrs_n = 1; dqm = 0; addr = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_mode(logic [7:0] key);
        nop_in();
        mrs_n = 0;
        addr  = {5'b0, key};
        push(cyc + 1, 33'h0, "R11");
        tick();
        nop_in();
        ilv_m = key[3];
        case (key[6:4])
            3'd0:    cl_m = 8;
            3'd1:    cl_m = 2;
            default: cl_m = int'(key[6:4]);
        endcase
    endtask

    task automatic do_act(logic [12:0] r);
        nop_in();
        ras_n = 0;
        addr  = r;
        push(cyc + 1, 33'h0, "R11");
        tick();
        nop_in();
        row_m = r;
    endtask

    // Refused read: the error flag rises and no beat follows for n edges.
    task automatic bad_read(string tag, int n);
        nop_in();
        cas_n = 0;
        addr  = 13'h0044;
        tick();
        nop_in();
        check({tag, " R10 err"}, {32'h0, ras_cas_err}, 33'h1);
        for (int k = 0; k < n; k++) begin
            push(cyc + 1, 33'h0, "R10");
            tick();
        end
    endtask

    // Read driver with a reference timing walk: mask, freeze window, deselect.
    task automatic do_read(logic [8:0] col, bit w, logic [7:0] dmask,
                           int fz_beat, int fz_len, bit cs_off, string tag);
        int          wait_m, beat, fz_left;
        bit          ckp, done, blank;
        logic [32:0] prev, e;
        logic [2:0]  lo;
        logic [8:0]  bc;
        nop_in();
        cas_n = 0;
        addr  = {4'b0, col};
        push(cyc + 1, 33'h0, "R11");
        tick();
        nop_in();
        wait_m = cl_m - 1; beat = 0; fz_left = 0;
        ckp = 1; done = 0; prev = '0;
        while (!done) begin
            nop_in();
            if (cs_off) begin
                cs_n = 1; dqm = 1; ras_n = 0; mrs_n = 0; addr = 13'h1FFF;
            end
            if (ckp) begin
                if (wait_m > 0) begin
                    wait_m--;
                    e = '0;
                end else if (beat < 8) begin
                    lo    = ilv_m ? (col[2:0] ^ 3'(beat)) : (col[2:0] + 3'(beat));
                    bc    = {col[8:3], lo};
                    blank = dmask[beat] && !cs_off;
                    if (!cs_off) dqm = dmask[beat];
                    e = blank ? 33'h0 : {1'b1, ref_word(row_m, bc, w)};
                    if (beat == fz_beat) fz_left = fz_len;
                    beat++;
                end else begin
                    e = '0;
                    done = 1;
                end
            end else begin
                e = prev;
            end
            cke = (fz_left > 0) ? 1'b0 : 1'b1;
            if (fz_left > 0) fz_left--;
            push(cyc + 1, e, tag);
            prev = e;
            ckp  = cke;
            tick();
        end
        cke = 1;
        nop_in();
    endtask

    task automatic drain();
        while (q_cyc.size() > 0) tick();
    endtask

    initial begin
        cke = 1; word_mode = 0; rst_n = 0;
        nop_in();
        repeat (3) tick();
        // R1: reset state of the outputs
        check("R1 reset out", {dout_valid, dout}, 33'h0);
        check("R1 reset err", {32'h0, ras_cas_err}, 33'h0);
        rst_n = 1;
        tick();

        // R10: a read with no row opened since reset is refused
        bad_read("R10 no row", 6);
        // R1 R4 R6: defaults (latency 2, sequential) with a row open
        do_act(13'h1A5C);
        do_read(9'h03D, 0, 8'h00, -1, 0, 0, "R1 R4 R6 default");
        drain();
        check("R10 err sticky", {32'h0, ras_cas_err}, 33'h1);
        // R3: low key bits set, latency 2 sequential; the mode cycle clears the error
        do_mode(8'h25);
        check("R10 err cleared", {32'h0, ras_cas_err}, 33'h0);
        do_read(9'h03D, 0, 8'h00, -1, 0, 0, "R3 key low bits");
        // R5: interleaved order, latency 5
        do_mode(8'h58);
        do_act(13'h0F0F);
        do_read(9'h0C6, 0, 8'h00, -1, 0, 0, "R5 interleaved");
        // R3: code 0 means latency 8, sequential wrap from 7
        do_mode(8'h00);
        do_read(9'h007, 0, 8'h00, -1, 0, 0, "R3 latency 8");
        // R8 R3: reserved code gives latency 2; masked beats are blanked
        do_mode(8'h10);
        do_read(9'h0A2, 0, 8'b0100_1001, -1, 0, 0, "R8 mask");
        // R7: word organisation, interleaved, latency 3
        drain();
        word_mode = 1;
        do_mode(8'h38);
        do_act(13'h15A3);
        do_read(9'h1F3, 1, 8'h00, -1, 0, 0, "R7 word mode");
        drain();
        tick();
        word_mode = 0;
        // R9: clock enable freeze mid-burst, latency 4
        do_mode(8'h40);
        do_read(9'h051, 0, 8'h00, 2, 3, 0, "R9 freeze");
        // R12: deselected strobes and mask ignored; the open row is kept
        do_read(9'h0E9, 0, 8'h00, -1, 0, 1, "R12 deselect");
        do_read(9'h012, 0, 8'h00, -1, 0, 0, "R12 row kept");
        // R10 R2: row latency 2; a read one edge after the open is refused, two is accepted
        do_mode(8'hB0);
        do_act(13'h0ABC);
        bad_read("R10 early", 0);
        do_read(9'h0B5, 0, 8'h00, -1, 0, 0, "R10 R2 on time");
        drain();
        check("R10 err held", {32'h0, ras_cas_err}, 33'h1);
        do_mode(8'hB0);
        check("R10 err clr", {32'h0, ras_cas_err}, 33'h0);
        drain();
        repeat (2) tick();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule